// File: doc/BRIEF.md
# Serially Configured Lookup Table

This block is a programmable lookup table with six logic inputs by default. Its truth table is a chain of storage bits, one per input combination. A one-bit serial port loads the chain, and every clock with the shift enable high moves it by one place. The logic inputs select one stored bit, and that bit reaches the output through combinational logic only. The last bit of the chain is driven out on a serial output, so several tables can be cascaded into a single configuration stream.

The table has two read modes. In full mode it is a single n-input function. In split mode it acts as two (n-1)-input functions that share the low select lines. The lower half of the chain drives output bit 0 and the upper half drives output bit 1. The table can also be written after loading, as a small single-bit RAM: a write strobe stores one data bit at the selected address.

Top module: `cfg_lut`

## Requirements
- R1: After reset every stored bit is 0, so both outputs and the serial output read 0 for every select value and in both modes.
- R2: Each clock edge with `cfg_shift_en` high moves the chain one place toward index 0 and puts `cfg_din` into index 2^n-1. After 2^n shifts, the k-th bit shifted in (counting from 0) sits at index k (LSB-first).
- R3: Reading is combinational. A change on `sel` or `split_mode` reaches `lut_out` without any clock edge.
- R4: While `cfg_shift_en` and `wr_en` are both low, the stored table does not change over any number of clocks.
- R5: `cfg_dout` always shows chain index 0, so after one more shift it shows the bit that was at index 1.
- R6: With `split_mode`=1, `lut_out[0]` is the bit at index {0,sel[n-2:0]} and `lut_out[1]` is the bit at index {1,sel[n-2:0]}. The top select bit `sel[n-1]` has no effect.
- R7: With `split_mode`=0, `lut_out[0]` is the bit at index `sel` and `lut_out[1]` is 0.
- R8: A clock edge with `wr_en` high and `cfg_shift_en` low stores `wr_data` at index `sel`, and every other index keeps its value.
- R9: When `cfg_shift_en` and `wr_en` are both high, the shift takes place and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_shift_en | input | 1 | Shifts the chain by one place per clock |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Chain index 0, used for cascading |
| split_mode | input | 1 | 0: one n-input table; 1: two (n-1)-input tables |
| wr_en | input | 1 | Single-bit write strobe (RAM use) |
| wr_data | input | 1 | Bit stored at index `sel` |
| sel | input | N_IN | Logic inputs / RAM address |
| lut_out | output | 2 | Table outputs |

## Verification
An irregular 64-bit pattern is loaded LSB-first, and its bits are then read at addresses 0, 1, 31, 32 and 63 and at a few addresses in between. A wrong shift direction or an off-by-one in the load shows up as a mismatch at these addresses. In split mode, the same low address is read with the top select bit both clear and set, which shows whether the halves are wired to the right output and whether the top bit is ignored. Writes change one bit whose neighbour is then read back unchanged. A clock with shift and write both high separates shift priority from write priority: the dropped write would have stored the complement of the bit that the shift moves into index 0.

// File: rtl/cfg_lut_pkg.sv
package cfg_lut_pkg;
  typedef enum logic {
    LUT_FULL  = 1'b0,
    LUT_SPLIT = 1'b1
  } lut_mode_e;

  localparam int unsigned LUT_OUTS = 2;
endpackage

// File: rtl/cfg_lut_chain.sv
module cfg_lut_chain #(
  parameter int unsigned N_IN  = 6,
  localparam int unsigned DEPTH = 1 << N_IN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             shift_din,
  input  logic             wr_en,
  input  logic             wr_data,
  input  logic [N_IN-1:0]  wr_addr,
  output logic [DEPTH-1:0] bits_q
);
  logic [DEPTH-1:0] bits_d;

  always_comb begin
    bits_d = bits_q;
    if (shift_en) begin
      bits_d = {shift_din, bits_q[DEPTH-1:1]};
    end else if (wr_en) begin
      bits_d[wr_addr] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
    end else if (shift_en || wr_en) begin
      bits_q <= bits_d;
    end
  end
endmodule

// File: rtl/cfg_lut_mux.sv
module cfg_lut_mux
  import cfg_lut_pkg::*;
#(
  parameter int unsigned N_IN  = 6,
  localparam int unsigned DEPTH = 1 << N_IN
) (
  input  logic [DEPTH-1:0]    table_bits,
  input  logic [N_IN-1:0]     sel,
  input  lut_mode_e           mode,
  output logic [LUT_OUTS-1:0] out
);
  logic full_bit;
  assign full_bit = table_bits[sel];

  generate
    if (N_IN >= 2) begin : g_split
      logic lo_bit, hi_bit;
      assign lo_bit = table_bits[{1'b0, sel[N_IN-2:0]}];
      assign hi_bit = table_bits[{1'b1, sel[N_IN-2:0]}];
      always_comb begin
        if (mode == LUT_SPLIT) out = {hi_bit, lo_bit};
        else                   out = {1'b0, full_bit};
      end
    end else begin : g_nosplit
      assign out = {1'b0, full_bit};
    end
  endgenerate
endmodule

// File: rtl/cfg_lut.sv
module cfg_lut
  import cfg_lut_pkg::*;
#(
  parameter int unsigned N_IN = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_shift_en,
  input  logic            cfg_din,
  output logic            cfg_dout,
  input  logic            split_mode,
  input  logic            wr_en,
  input  logic            wr_data,
  input  logic [N_IN-1:0] sel,
  output logic [1:0]      lut_out
);
  localparam int unsigned DEPTH = 1 << N_IN;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [DEPTH-1:0] table_q;
  lut_mode_e        mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];
  assign mode      = lut_mode_e'(split_mode);

  cfg_lut_chain #(.N_IN(N_IN)) chain_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .shift_en  (cfg_shift_en),
    .shift_din (cfg_din),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .wr_addr   (sel),
    .bits_q    (table_q)
  );

  cfg_lut_mux #(.N_IN(N_IN)) mux_i (
    .table_bits (table_q),
    .sel        (sel),
    .mode       (mode),
    .out        (lut_out)
  );

  assign cfg_dout = table_q[0];

  assert_shift_entry_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    cfg_shift_en |=> table_q[DEPTH-1] == $past(cfg_din));

  assert_dout_follows_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    cfg_shift_en |=> cfg_dout == $past(table_q[1]));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!cfg_shift_en && !wr_en) |=> $stable(table_q));

  assert_write_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && !cfg_shift_en && sel == '0) |=> cfg_dout == $past(wr_data));

  assert_full_read_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !split_mode |-> (lut_out[0] == table_q[sel] && !lut_out[1]));

  assert_split_read_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    split_mode |-> lut_out[1] == table_q[{1'b1, sel[N_IN-2:0]}]);
endmodule

// File: tb/cfg_lut_tb_top.sv
module cfg_lut_tb_top;
  localparam int unsigned N_IN = 6;
  localparam logic [63:0] PAT  = 64'h9E37_79B9_7F4A_7C15;
  localparam int unsigned NVEC = 12;
  // each vector: {split_mode, sel[5:0]}
  localparam logic [6:0] VEC [NVEC] = '{
    7'b0_000000, 7'b0_000001, 7'b0_011111, 7'b0_100000,
    7'b0_111111, 7'b0_101101, 7'b0_010010, 7'b1_000000,
    7'b1_100000, 7'b1_011111, 7'b1_111111, 7'b1_000111
  };

  logic clk = 1'b0;
  logic rst_n, cfg_shift_en, cfg_din, split_mode, wr_en, wr_data;
  logic [N_IN-1:0] sel;
  logic cfg_dout;
  logic [1:0] lut_out;
  logic [63:0] model;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  cfg_lut #(.N_IN(N_IN)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_shift_en(cfg_shift_en), .cfg_din(cfg_din),
    .cfg_dout(cfg_dout), .split_mode(split_mode), .wr_en(wr_en),
    .wr_data(wr_data), .sel(sel), .lut_out(lut_out)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b (sel=%0d split=%0b)", req, act, exp, sel, split_mode);
    end
  endtask

  function automatic logic [1:0] expect_out(input logic [63:0] t, input logic sm, input logic [5:0] s);
    if (sm) return {t[{1'b1, s[4:0]}], t[{1'b0, s[4:0]}]};
    return {1'b0, t[s]};
  endfunction

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_shift_en = 1'b0; cfg_din = 1'b0; split_mode = 1'b0;
    wr_en = 1'b0; wr_data = 1'b0; sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state in both modes
    for (int s = 0; s < 64; s += 21) begin
      sel = 6'(s); split_mode = 1'b0; #1;
      check("R1", lut_out, 2'b00);
      split_mode = 1'b1; #1;
      check("R1", lut_out, 2'b00);
    end
    check("R1 dout", {1'b0, cfg_dout}, 2'b00);

    // R2: load LSB-first
    split_mode = 1'b0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); cfg_shift_en = 1'b1; cfg_din = PAT[i];
    end
    @(negedge clk); cfg_shift_en = 1'b0;
    model = PAT;

    // R3 R6 R7: vector walk, sel changed with no clock edge in between
    for (int v = 0; v < NVEC; v++) begin
      split_mode = VEC[v][6]; sel = VEC[v][5:0]; #1;
      check(VEC[v][6] ? "R6" : "R2/R3/R7", lut_out, expect_out(model, VEC[v][6], VEC[v][5:0]));
    end
    // R6: top select bit ignored in split mode
    split_mode = 1'b1; sel = 6'd9; #1;
    check("R6", lut_out, {model[41], model[9]});
    sel = 6'd41; #1;
    check("R6", lut_out, {model[41], model[9]});

    // R5: serial output shows index 0
    check("R5", {1'b0, cfg_dout}, {1'b0, model[0]});

    // R4: idle clocks keep the table
    split_mode = 1'b0;
    repeat (10) @(negedge clk);
    sel = 6'd63; #1;
    check("R4", lut_out, {1'b0, model[63]});
    sel = 6'd20; #1;
    check("R4", lut_out, {1'b0, model[20]});

    // R8: single-bit write at index 10
    @(negedge clk); sel = 6'd10; wr_data = ~model[10]; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    model[10] = ~model[10];
    #1 check("R8", lut_out, {1'b0, model[10]});
    sel = 6'd11; #1;
    check("R8 neighbour", lut_out, {1'b0, model[11]});

    // R9 R5: shift and write together, shift wins
    @(negedge clk); sel = 6'd0; wr_en = 1'b1; wr_data = ~model[1];
    cfg_shift_en = 1'b1; cfg_din = ~model[63];
    @(negedge clk); wr_en = 1'b0; cfg_shift_en = 1'b0;
    model = {~PAT[63], model[63:1]};
    #1 check("R9", lut_out, {1'b0, model[0]});
    check("R5 after shift", {1'b0, cfg_dout}, {1'b0, model[0]});
    sel = 6'd63; #1;
    check("R2 entry", lut_out, {1'b0, model[63]});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule